// File: doc/BRIEF.md
# Reset-Time Slot Width Detector

This block combines the two halves of slot-width discovery for a device with a 64-bit data path. The board half is a reset sequencer. It holds the bus reset low while the supply reports power not good. It pulls the wide-transfer request line low for the whole of that reset. Once power is good and a programmable number of clocks has passed, it releases both lines on the same clock.

The device half watches the bus reset and the wide-request line as it sees them at its own pins. It tracks the request line during reset and freezes the value it held on the last clock before reset ended. From that value it records whether the slot is wide or narrow, and keeps the result until the next reset.

A wide slot has board pull-ups on the upper lanes. There the device's own upper-lane drive passes straight through. A narrow slot leaves the upper lanes unconnected. There the block drives the upper address/data lanes, the upper byte enables and the upper parity bit at all times, using fixed values, and it ignores the core's drive. While the bus is in reset the upper lanes are not driven at all.

Top module: `slot_width_probe`

## Requirements
- R1: While `pwr_ok` is 0, `brd_rst_n_o` and `brd_wreq_n_o` are both 0 with no clock delay.
- R2: After `pwr_ok` rises, both board outputs stay 0 through the first HOLD_CYCLES-1 rising edges at which `pwr_ok` is sampled 1. Both become 1 at the HOLD_CYCLES-th such edge and remain 1 while `pwr_ok` stays 1.
- R3: `brd_rst_n_o` and `brd_wreq_n_o` change on the same clock and always carry equal values.
- R4: While `bus_rst_n_i` is 0, `slot_known_o` is 0 and all three upper-lane output enables are 0, whatever the core requests.
- R5: At the first rising edge where `bus_rst_n_i` is sampled 1 after being 0, `slot_known_o` becomes 1. `slot_narrow_o` then equals the value `bus_wreq_n_i` had at the last edge where `bus_rst_n_i` was sampled 0 (1 = narrow slot, 0 = wide slot).
- R6: While `bus_rst_n_i` stays 1, `slot_narrow_o` does not change, whatever `bus_wreq_n_i` does.
- R7: In a wide slot with `slot_known_o` at 1, each upper-lane output and output enable equals the matching core input with no clock delay.
- R8: In a narrow slot with `slot_known_o` at 1, all three output enables are 1. The outputs take fixed values: `ext_ad_o` = PARK_AD (default all ones), `ext_cbe_o` = PARK_BE (default all ones), and `ext_par_o` = even parity over those two values (0 for the defaults). Core inputs have no effect.
- R9: A drop of `pwr_ok` during or after the release count clears the count. The next rise of `pwr_ok` waits a full HOLD_CYCLES edges again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pwr_ok | input | 1 | Supply power-good, high when power is stable |
| brd_rst_n_o | output | 1 | Board-driven bus reset, active low |
| brd_wreq_n_o | output | 1 | Board-driven wide-request line during reset, active low |
| bus_rst_n_i | input | 1 | Bus reset as seen at the device pin, active low |
| bus_wreq_n_i | input | 1 | Wide-request line as seen at the device pin, active low |
| core_ad_hi_i | input | AD_W | Core's upper address/data drive value |
| core_ad_hi_oe_i | input | 1 | Core's upper address/data drive enable |
| core_cbe_hi_i | input | BE_W | Core's upper command/byte-enable drive value |
| core_cbe_hi_oe_i | input | 1 | Core's upper command/byte-enable drive enable |
| core_par_hi_i | input | 1 | Core's upper parity drive value |
| core_par_hi_oe_i | input | 1 | Core's upper parity drive enable |
| ext_ad_o | output | AD_W | Upper address/data pad value |
| ext_ad_oe_o | output | 1 | Upper address/data pad enable |
| ext_cbe_o | output | BE_W | Upper command/byte-enable pad value |
| ext_cbe_oe_o | output | 1 | Upper command/byte-enable pad enable |
| ext_par_o | output | 1 | Upper parity pad value |
| ext_par_oe_o | output | 1 | Upper parity pad enable |
| slot_known_o | output | 1 | Slot width has been decided since the last reset |
| slot_narrow_o | output | 1 | 1 = narrow slot, 0 = wide slot (valid when slot_known_o is 1) |

## Verification
The bench builds the block with HOLD_CYCLES set to 4 and the default lane widths of 32 and 4. With that count, every edge of the release window can be checked one by one. The count is also large enough to cut power off two edges into the window and confirm that counting restarts from zero. The bench models the two slot kinds by wiring the device's request input either to the board's request output or to a constant high. It can also take that pin over directly, to confirm the latched width ignores the pin after reset.

// File: rtl/slot_probe_pkg.sv
package slot_probe_pkg;

  typedef enum logic [1:0] {
    SLOT_UNKNOWN = 2'd0,
    SLOT_WIDE    = 2'd1,
    SLOT_NARROW  = 2'd2
  } slot_kind_e;

  // Counter width able to hold values 0..n
  function automatic int count_bits(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

  // Map a sampled active-low request level to a slot kind
  function automatic slot_kind_e kind_from_req(input logic req_n);
    return req_n ? SLOT_NARROW : SLOT_WIDE;
  endfunction

endpackage

// File: rtl/board_rst_seq.sv
module board_rst_seq #(
  parameter int HOLD_CYCLES = 16
) (
  input  logic clk,
  input  logic pwr_ok,
  output logic brd_rst_n_o,
  output logic brd_wreq_n_o,
  output logic hold_done_o
);
  import slot_probe_pkg::*;

  localparam int CW = count_bits(HOLD_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          rel_q;

  always_ff @(posedge clk) begin
    if (!pwr_ok) begin
      cnt_q <= '0;
      rel_q <= 1'b0;
    end else if (!rel_q) begin
      if (cnt_q == LAST) rel_q <= 1'b1;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end

  // Power loss forces both lines low at once, without waiting for a clock
  assign hold_done_o  = rel_q & pwr_ok;
  assign brd_rst_n_o  = hold_done_o;
  assign brd_wreq_n_o = hold_done_o;

endmodule

// File: rtl/slot_width_latch.sv
module slot_width_latch (
  input  logic clk,
  input  logic bus_rst_n_i,
  input  logic bus_wreq_n_i,
  output logic known_o,
  output logic narrow_o,
  output logic trail_o
);
  import slot_probe_pkg::*;

  slot_kind_e kind_q;
  logic       req_smp_q;

  // Track the request level for as long as reset is seen low
  always_ff @(posedge clk) begin
    if (!bus_rst_n_i) req_smp_q <= bus_wreq_n_i;
  end

  always_ff @(posedge clk) begin
    if (!bus_rst_n_i)                kind_q <= SLOT_UNKNOWN;
    else if (kind_q == SLOT_UNKNOWN) kind_q <= kind_from_req(req_smp_q);
  end

  assign trail_o  = bus_rst_n_i & (kind_q == SLOT_UNKNOWN);
  assign known_o  = bus_rst_n_i & (kind_q != SLOT_UNKNOWN);
  assign narrow_o = (kind_q == SLOT_NARROW);

endmodule

// File: rtl/ext_lane_park.sv
module ext_lane_park #(
  parameter int              AD_W    = 32,
  parameter int              BE_W    = 4,
  parameter logic [AD_W-1:0] PARK_AD = '1,
  parameter logic [BE_W-1:0] PARK_BE = '1
) (
  input  logic            known_i,
  input  logic            narrow_i,
  input  logic [AD_W-1:0] core_ad_i,
  input  logic            core_ad_oe_i,
  input  logic [BE_W-1:0] core_cbe_i,
  input  logic            core_cbe_oe_i,
  input  logic            core_par_i,
  input  logic            core_par_oe_i,
  output logic [AD_W-1:0] ad_o,
  output logic            ad_oe_o,
  output logic [BE_W-1:0] cbe_o,
  output logic            cbe_oe_o,
  output logic            par_o,
  output logic            par_oe_o,
  output logic            parked_o
);

  function automatic logic even_par(input logic [AD_W-1:0] a,
                                    input logic [BE_W-1:0] b);
    return ^{a, b};
  endfunction

  localparam logic PARK_PAR = even_par(PARK_AD, PARK_BE);

  logic pass;
  assign parked_o = known_i & narrow_i;
  assign pass     = known_i & ~narrow_i;

  always_comb begin
    ad_o     = parked_o ? PARK_AD  : core_ad_i;
    cbe_o    = parked_o ? PARK_BE  : core_cbe_i;
    par_o    = parked_o ? PARK_PAR : core_par_i;
    ad_oe_o  = parked_o | (pass & core_ad_oe_i);
    cbe_oe_o = parked_o | (pass & core_cbe_oe_i);
    par_oe_o = parked_o | (pass & core_par_oe_i);
  end

endmodule

// File: rtl/slot_width_probe.sv
module slot_width_probe #(
  parameter int              HOLD_CYCLES = 16,
  parameter int              AD_W        = 32,
  parameter int              BE_W        = 4,
  parameter logic [AD_W-1:0] PARK_AD     = '1,
  parameter logic [BE_W-1:0] PARK_BE     = '1
) (
  input  logic            clk,
  input  logic            pwr_ok,
  output logic            brd_rst_n_o,
  output logic            brd_wreq_n_o,
  input  logic            bus_rst_n_i,
  input  logic            bus_wreq_n_i,
  input  logic [AD_W-1:0] core_ad_hi_i,
  input  logic            core_ad_hi_oe_i,
  input  logic [BE_W-1:0] core_cbe_hi_i,
  input  logic            core_cbe_hi_oe_i,
  input  logic            core_par_hi_i,
  input  logic            core_par_hi_oe_i,
  output logic [AD_W-1:0] ext_ad_o,
  output logic            ext_ad_oe_o,
  output logic [BE_W-1:0] ext_cbe_o,
  output logic            ext_cbe_oe_o,
  output logic            ext_par_o,
  output logic            ext_par_oe_o,
  output logic            slot_known_o,
  output logic            slot_narrow_o
);

  logic hold_done;
  logic det_trail;
  logic lanes_parked;

  board_rst_seq #(.HOLD_CYCLES(HOLD_CYCLES)) u_seq (
    .clk          (clk),
    .pwr_ok       (pwr_ok),
    .brd_rst_n_o  (brd_rst_n_o),
    .brd_wreq_n_o (brd_wreq_n_o),
    .hold_done_o  (hold_done)
  );

  slot_width_latch u_det (
    .clk          (clk),
    .bus_rst_n_i  (bus_rst_n_i),
    .bus_wreq_n_i (bus_wreq_n_i),
    .known_o      (slot_known_o),
    .narrow_o     (slot_narrow_o),
    .trail_o      (det_trail)
  );

  ext_lane_park #(
    .AD_W(AD_W), .BE_W(BE_W), .PARK_AD(PARK_AD), .PARK_BE(PARK_BE)
  ) u_park (
    .known_i       (slot_known_o),
    .narrow_i      (slot_narrow_o),
    .core_ad_i     (core_ad_hi_i),
    .core_ad_oe_i  (core_ad_hi_oe_i),
    .core_cbe_i    (core_cbe_hi_i),
    .core_cbe_oe_i (core_cbe_hi_oe_i),
    .core_par_i    (core_par_hi_i),
    .core_par_oe_i (core_par_hi_oe_i),
    .ad_o          (ext_ad_o),
    .ad_oe_o       (ext_ad_oe_o),
    .cbe_o         (ext_cbe_o),
    .cbe_oe_o      (ext_cbe_oe_o),
    .par_o         (ext_par_o),
    .par_oe_o      (ext_par_oe_o),
    .parked_o      (lanes_parked)
  );

endmodule

// File: rtl/slot_width_probe_chk.sv
module slot_width_probe_chk #(
  parameter int              HOLD_CYCLES = 16,
  parameter int              AD_W        = 32,
  parameter int              BE_W        = 4,
  parameter logic [AD_W-1:0] PARK_AD     = '1,
  parameter logic [BE_W-1:0] PARK_BE     = '1
) (
  input logic            clk,
  input logic            pwr_ok,
  input logic            brd_rst_n_o,
  input logic            brd_wreq_n_o,
  input logic            bus_rst_n_i,
  input logic [AD_W-1:0] core_ad_hi_i,
  input logic            core_ad_hi_oe_i,
  input logic [AD_W-1:0] ext_ad_o,
  input logic            ext_ad_oe_o,
  input logic [BE_W-1:0] ext_cbe_o,
  input logic            ext_cbe_oe_o,
  input logic            ext_par_oe_o,
  input logic            slot_known_o,
  input logic            slot_narrow_o,
  input logic            det_trail,
  input logic            lanes_parked
);
  localparam int PW = $clog2(HOLD_CYCLES + 2) + 1;
  localparam logic [PW-1:0] HOLD = PW'(HOLD_CYCLES);

  // Independent count of edges seen with power good, saturating past HOLD
  logic [PW-1:0] pg_cnt;
  always_ff @(posedge clk) begin
    if (!pwr_ok)            pg_cnt <= '0;
    else if (pg_cnt <= HOLD) pg_cnt <= pg_cnt + 1'b1;
  end

  a_r1_reset_without_power: assert property (@(posedge clk)
    !pwr_ok |-> (!brd_rst_n_o && !brd_wreq_n_o));

  a_r2_no_early_release: assert property (@(posedge clk) disable iff (!pwr_ok)
    brd_rst_n_o |-> (pg_cnt >= HOLD));

  a_r2_release_not_late: assert property (@(posedge clk) disable iff (!pwr_ok)
    (pg_cnt > HOLD) |-> brd_rst_n_o);

  a_r3_lines_paired: assert property (@(posedge clk) disable iff (!pwr_ok)
    $rose(brd_rst_n_o) |-> $rose(brd_wreq_n_o));

  a_r4_quiet_in_reset: assert property (@(posedge clk)
    !bus_rst_n_i |-> (!slot_known_o && !ext_ad_oe_o && !ext_cbe_oe_o && !ext_par_oe_o));

  a_r5_known_after_trail: assert property (@(posedge clk) disable iff (!bus_rst_n_i)
    det_trail |=> slot_known_o);

  a_r6_flag_held: assert property (@(posedge clk) disable iff (!bus_rst_n_i)
    slot_known_o |=> $stable(slot_narrow_o));

  a_r7_wide_passes: assert property (@(posedge clk) disable iff (!bus_rst_n_i)
    (slot_known_o && !slot_narrow_o) |-> (ext_ad_o == core_ad_hi_i && ext_ad_oe_o == core_ad_hi_oe_i));

  a_r8_narrow_parked: assert property (@(posedge clk) disable iff (!bus_rst_n_i)
    lanes_parked |-> (ext_ad_oe_o && ext_cbe_oe_o && ext_par_oe_o &&
                      ext_ad_o == PARK_AD && ext_cbe_o == PARK_BE));

endmodule

bind slot_width_probe slot_width_probe_chk #(
  .HOLD_CYCLES(HOLD_CYCLES), .AD_W(AD_W), .BE_W(BE_W),
  .PARK_AD(PARK_AD), .PARK_BE(PARK_BE)
) u_chk (.*);

// File: tb/slot_width_probe_tb.sv
module slot_width_probe_tb;
  localparam int HOLD = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        pwr_ok = 1'b0;
  logic        narrow_slot = 1'b0, pin_ovr = 1'b0, pin_val = 1'b0;
  logic        brd_rst_n, brd_wreq_n, bus_wreq_n;
  logic [31:0] c_ad = '0;  logic c_ad_oe = 1'b0;
  logic [3:0]  c_be = '0;  logic c_be_oe = 1'b0;
  logic        c_par = 1'b0, c_par_oe = 1'b0;
  logic [31:0] x_ad; logic x_ad_oe;
  logic [3:0]  x_be; logic x_be_oe;
  logic        x_par, x_par_oe, known, narrow;

  assign bus_wreq_n = pin_ovr ? pin_val : (narrow_slot ? 1'b1 : brd_wreq_n);

  slot_width_probe #(.HOLD_CYCLES(HOLD)) u_dut (
    .clk(clk), .pwr_ok(pwr_ok), .brd_rst_n_o(brd_rst_n), .brd_wreq_n_o(brd_wreq_n),
    .bus_rst_n_i(brd_rst_n), .bus_wreq_n_i(bus_wreq_n),
    .core_ad_hi_i(c_ad), .core_ad_hi_oe_i(c_ad_oe), .core_cbe_hi_i(c_be),
    .core_cbe_hi_oe_i(c_be_oe), .core_par_hi_i(c_par), .core_par_hi_oe_i(c_par_oe),
    .ext_ad_o(x_ad), .ext_ad_oe_o(x_ad_oe), .ext_cbe_o(x_be), .ext_cbe_oe_o(x_be_oe),
    .ext_par_o(x_par), .ext_par_oe_o(x_par_oe),
    .slot_known_o(known), .slot_narrow_o(narrow)
  );

  int checks = 0, failures = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Vector: [39:8] ad, [7:4] cbe, [3] par, [2] ad_oe, [1] cbe_oe, [0] par_oe
  localparam logic [39:0] VEC [6] = '{
    {32'h0000_0000, 4'h0, 1'b0, 3'b111},
    {32'hDEAD_BEEF, 4'hA, 1'b1, 3'b101},
    {32'h1234_5678, 4'h5, 1'b0, 3'b010},
    {32'hFFFF_0000, 4'hF, 1'b1, 3'b000},
    {32'h8000_0001, 4'h3, 1'b1, 3'b111},
    {32'h0F0F_F0F0, 4'hC, 1'b0, 3'b100}
  };

  task automatic edge_step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic walk(input bit parked);
    for (int i = 0; i < 6; i++) begin
      {c_ad, c_be, c_par, c_ad_oe, c_be_oe, c_par_oe} = VEC[i];
      #1;
      if (!parked) begin
        chk("R7 ad", x_ad, VEC[i][39:8]);
        chk("R7 cbe", x_be, VEC[i][7:4]);
        chk("R7 par", x_par, VEC[i][3]);
        chk("R7 oe", {x_ad_oe, x_be_oe, x_par_oe}, VEC[i][2:0]);
      end else begin
        chk("R8 ad", x_ad, 32'hFFFF_FFFF);
        chk("R8 cbe", x_be, 4'hF);
        chk("R8 par", x_par, 1'b0); // 36 ones: even count, parity bit 0
        chk("R8 oe", {x_ad_oe, x_be_oe, x_par_oe}, 3'b111);
      end
      edge_step();
    end
  endtask

  // Raise power and walk the release window edge by edge
  task automatic power_up(input string tag);
    pwr_ok = 1'b1;
    for (int k = 1; k <= HOLD; k++) begin
      edge_step();
      chk({tag, " R2 reset"}, brd_rst_n, (k == HOLD));
      chk({tag, " R3 paired"}, brd_wreq_n, brd_rst_n);
    end
  endtask

  initial begin
    repeat (3) edge_step();
    chk("R1 rst", brd_rst_n, 0);
    chk("R1 wreq", brd_wreq_n, 0);
    c_ad_oe = 1; c_be_oe = 1; c_par_oe = 1; #1;
    chk("R4 known", known, 0);
    chk("R4 oe", {x_ad_oe, x_be_oe, x_par_oe}, 3'b000);

    power_up("wide");
    chk("R4 before trail", known, 0);
    edge_step();
    chk("R5 known", known, 1);
    chk("R5 wide", narrow, 0);
    walk(1'b0);

    pin_ovr = 1; pin_val = 1; edge_step(); edge_step();
    chk("R6 wide held", narrow, 0);
    pin_ovr = 0;

    // R9: power loss and restart mid-window; also switch to a narrow slot
    pwr_ok = 0; #1;
    chk("R9 immediate", brd_rst_n, 0);
    chk("R4 drop known", known, 0);
    chk("R4 drop oe", {x_ad_oe, x_be_oe, x_par_oe}, 3'b000);
    narrow_slot = 1;
    edge_step();
    pwr_ok = 1; edge_step(); edge_step();
    chk("R9 partial", brd_rst_n, 0);
    pwr_ok = 0; edge_step();
    power_up("R9 restart");
    edge_step();
    chk("R5 known narrow", known, 1);
    chk("R5 narrow", narrow, 1);
    walk(1'b1);

    pin_ovr = 1; pin_val = 0; edge_step(); edge_step();
    chk("R6 narrow held", narrow, 1);
    chk("R8 still parked", x_ad_oe, 1);
    pin_ovr = 0;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule